// File: doc/BRIEF.md
# Subchannel Engine Binding Router

This block sits between a command stream and four execution engines: a 2D engine, a 3D engine, a compute engine and a DMA copy engine. Each incoming write carries a method number, a subchannel number, a 32-bit value and a remaining-argument count. The block keeps a routing table with one entry per subchannel. Each entry holds an engine identifier and a bound flag.

A write to method 0 is a bind command. The value of that write becomes the entry for its subchannel, and nothing is sent to any engine. Methods 1 to 0x3F are reserved. They are dropped and raise a sticky flag. Every method of 0x40 or more is forwarded to the engine whose identifier matches the subchannel's entry. A write on an unbound subchannel is dropped and raises its own sticky flag. So is a write on a subchannel whose stored identifier matches no engine. Only the 3D port carries the remaining count.

Both the transaction input and each engine port use valid/ready. A beat moves when valid and ready are both high at a clock edge. The input accepts a beat only while the single output register is empty, or is being drained by its target engine in that cycle. A stalled engine therefore holds its beat stable and stops the input. Bind, reserved and dropped writes never wait for an engine, except behind a beat that is already stalled. The error flags are plain level outputs, and all three are cleared together by a clear input.

Top module: `subch_router`

## Requirements
- R1: After reset, every subchannel is unbound, all four engine valids are low, all three error flags are low and in_ready is high.
- R2: An accepted write with method 0 stores the full 32-bit value as the binding of its subchannel, replacing any earlier binding. No engine valid rises for it.
- R3: An accepted write with a method from 1 to 0x3F is not delivered to any engine, and err_reserved is high from the next cycle.
- R4: An accepted write with method 0x40 or above, on a subchannel whose binding equals a configured engine identifier zero-extended to 32 bits, is presented on that engine's port one cycle later with unchanged method and value. The port is 2D for ID_2D, 3D for ID_3D, compute for ID_CMP and DMA for ID_DMA.
- R5: The 3D port additionally carries the remaining count of the forwarded write. The other ports have no such field.
- R6: A forwarded-range write on a subchannel that has never been bound since reset is dropped, and err_unbound is high from the next cycle.
- R7: A forwarded-range write on a subchannel bound to a value that matches no engine identifier is dropped, and err_unknown is high from the next cycle. Any nonzero bit above bit 15 counts as a mismatch.
- R8: While an engine valid is high and its ready is low, that port's valid, method and value stay unchanged and in_ready is low. in_ready is high exactly when the output register is empty or its target is ready.
- R9: At most one engine valid is high in any cycle.
- R10: A binding applies to the very next accepted write on that subchannel. Rebinding one subchannel does not change the routing of another.
- R11: Error flags stay high until a cycle with err_clear high. A new error in that same cycle leaves its flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_clear | input | 1 | Clears all sticky error flags |
| in_valid | input | 1 | Incoming write is present |
| in_ready | output | 1 | Block accepts the incoming write |
| in_method | input | 13 | Method number |
| in_subch | input | 3 | Subchannel number |
| in_value | input | 32 | Write value, or engine identifier for a bind |
| in_remain | input | 16 | Arguments remaining after this one |
| eng2d_valid | output | 1 | 2D write present |
| eng2d_ready | input | 1 | 2D engine takes the write |
| eng2d_method | output | 13 | 2D method |
| eng2d_value | output | 32 | 2D value |
| eng3d_valid | output | 1 | 3D write present |
| eng3d_ready | input | 1 | 3D engine takes the write |
| eng3d_method | output | 13 | 3D method |
| eng3d_value | output | 32 | 3D value |
| eng3d_remain | output | 16 | 3D remaining count |
| cmp_valid | output | 1 | Compute write present |
| cmp_ready | input | 1 | Compute engine takes the write |
| cmp_method | output | 13 | Compute method |
| cmp_value | output | 32 | Compute value |
| dma_valid | output | 1 | DMA copy write present |
| dma_ready | input | 1 | DMA copy engine takes the write |
| dma_method | output | 13 | DMA method |
| dma_value | output | 32 | DMA value |
| err_unbound | output | 1 | Sticky: write on an unbound subchannel |
| err_reserved | output | 1 | Sticky: reserved method written |
| err_unknown | output | 1 | Sticky: subchannel bound to an unknown identifier |

## Verification
Each engine is bound on its own subchannel and sent a distinct method and value. Checking that only the intended port fires tells apart routing by binding from routing by subchannel number. Methods 0, 1, 0x3F and 0x40 probe both edges of the reserved range. A binding with only upper bits differing from a valid identifier separates a full-width compare from a truncated one. A held-low ready, a back-to-back bind-then-write, and a clear that coincides with a new error exercise the stall, binding-order and flag-priority paths.

// File: rtl/subch_router_pkg.sv
package subch_router_pkg;

  localparam int NUM_ENG = 4;

  typedef enum logic [1:0] {
    ENG_2D  = 2'd0,
    ENG_3D  = 2'd1,
    ENG_CMP = 2'd2,
    ENG_DMA = 2'd3
  } eng_sel_e;

  typedef enum logic [2:0] {
    ACT_BIND     = 3'd0,
    ACT_RESERVED = 3'd1,
    ACT_FWD      = 3'd2,
    ACT_UNBOUND  = 3'd3,
    ACT_UNKNOWN  = 3'd4
  } act_e;

endpackage

// File: rtl/subch_bind_table.sv
module subch_bind_table #(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_val,
  output logic              rd_bound
);

  logic [DATA_W-1:0] ent_q [ENTRIES];
  logic [ENTRIES-1:0] bound_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[e]   <= '0;
        bound_q[e] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        ent_q[e]   <= wr_val;
        bound_q[e] <= 1'b1;
      end
    end
  end

  assign rd_val   = ent_q[rd_idx];
  assign rd_bound = bound_q[rd_idx];

endmodule

// File: rtl/subch_method_decode.sv
module subch_method_decode
  import subch_router_pkg::*;
#(
  parameter int METHOD_W   = 13,
  parameter int DATA_W     = 32,
  parameter int ID_W       = 16,
  parameter int RESV_LIMIT = 'h40,
  parameter logic [NUM_ENG-1:0][ID_W-1:0] ENG_IDS = '0
) (
  input  logic [METHOD_W-1:0] method,
  input  logic                bound,
  input  logic [DATA_W-1:0]   bound_val,
  output act_e                act,
  output eng_sel_e            sel
);

  logic [NUM_ENG-1:0] hit;

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_cmp
    assign hit[k] = (bound_val == {{(DATA_W-ID_W){1'b0}}, ENG_IDS[k]});
  end

  always_comb begin
    sel = ENG_2D;
    for (int k = NUM_ENG - 1; k >= 0; k--) begin
      if (hit[k]) sel = eng_sel_e'(2'(k));
    end
  end

  always_comb begin
    if (method == '0)                          act = ACT_BIND;
    else if (method < METHOD_W'(RESV_LIMIT))   act = ACT_RESERVED;
    else if (!bound)                           act = ACT_UNBOUND;
    else if (hit == '0)                        act = ACT_UNKNOWN;
    else                                       act = ACT_FWD;
  end

endmodule

// File: rtl/subch_fwd_stage.sv
module subch_fwd_stage
  import subch_router_pkg::*;
#(
  parameter int METHOD_W = 13,
  parameter int DATA_W   = 32,
  parameter int REM_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  eng_sel_e            load_sel,
  input  logic [METHOD_W-1:0] load_method,
  input  logic [DATA_W-1:0]   load_value,
  input  logic [REM_W-1:0]    load_remain,
  input  logic [NUM_ENG-1:0]  port_ready,
  output logic [NUM_ENG-1:0]  port_valid,
  output logic [METHOD_W-1:0] out_method,
  output logic [DATA_W-1:0]   out_value,
  output logic [REM_W-1:0]    out_remain,
  output logic                can_take
);

  logic     full_q;
  eng_sel_e sel_q;
  logic     drain;

  assign drain    = full_q && port_ready[sel_q];
  assign can_take = !full_q || port_ready[sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      sel_q      <= ENG_2D;
      out_method <= '0;
      out_value  <= '0;
      out_remain <= '0;
    end else if (load) begin
      full_q     <= 1'b1;
      sel_q      <= load_sel;
      out_method <= load_method;
      out_value  <= load_value;
      out_remain <= load_remain;
    end else if (drain) begin
      full_q     <= 1'b0;
    end
  end

  for (genvar p = 0; p < NUM_ENG; p++) begin : g_vld
    assign port_valid[p] = full_q && (sel_q == eng_sel_e'(2'(p)));
  end

endmodule

// File: rtl/subch_err_flags.sv
module subch_err_flags #(
  parameter int FLAGS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLAGS-1:0] set,
  input  logic             clr,
  output logic [FLAGS-1:0] flag
);

  for (genvar f = 0; f < FLAGS; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[f] <= 1'b0;
      else if (set[f]) flag[f] <= 1'b1;
      else if (clr)    flag[f] <= 1'b0;
    end
  end

endmodule

// File: rtl/subch_router.sv
module subch_router
  import subch_router_pkg::*;
#(
  parameter int SUBCH_COUNT = 8,
  parameter int METHOD_W    = 13,
  parameter int DATA_W      = 32,
  parameter int REM_W       = 16,
  parameter int ID_W        = 16,
  parameter int RESV_LIMIT  = 'h40,
  parameter logic [ID_W-1:0] ID_2D  = 16'h0201,
  parameter logic [ID_W-1:0] ID_3D  = 16'h0302,
  parameter logic [ID_W-1:0] ID_CMP = 16'h0403,
  parameter logic [ID_W-1:0] ID_DMA = 16'h0504,
  localparam int SUB_W = (SUBCH_COUNT > 1) ? $clog2(SUBCH_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                err_clear,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [METHOD_W-1:0] in_method,
  input  logic [SUB_W-1:0]    in_subch,
  input  logic [DATA_W-1:0]   in_value,
  input  logic [REM_W-1:0]    in_remain,
  output logic                eng2d_valid,
  input  logic                eng2d_ready,
  output logic [METHOD_W-1:0] eng2d_method,
  output logic [DATA_W-1:0]   eng2d_value,
  output logic                eng3d_valid,
  input  logic                eng3d_ready,
  output logic [METHOD_W-1:0] eng3d_method,
  output logic [DATA_W-1:0]   eng3d_value,
  output logic [REM_W-1:0]    eng3d_remain,
  output logic                cmp_valid,
  input  logic                cmp_ready,
  output logic [METHOD_W-1:0] cmp_method,
  output logic [DATA_W-1:0]   cmp_value,
  output logic                dma_valid,
  input  logic                dma_ready,
  output logic [METHOD_W-1:0] dma_method,
  output logic [DATA_W-1:0]   dma_value,
  output logic                err_unbound,
  output logic                err_reserved,
  output logic                err_unknown
);

  localparam logic [NUM_ENG-1:0][ID_W-1:0] ENG_IDS = {ID_DMA, ID_CMP, ID_3D, ID_2D};

  logic                accept;
  logic [DATA_W-1:0]   lk_val;
  logic                lk_bound;
  act_e                act;
  eng_sel_e            sel;
  logic [NUM_ENG-1:0]  pv;
  logic [NUM_ENG-1:0]  pr;
  logic [METHOD_W-1:0] st_method;
  logic [DATA_W-1:0]   st_value;
  logic [REM_W-1:0]    st_remain;
  logic                can_take;
  logic [2:0]          err_set;
  logic [2:0]          err_q;

  assign in_ready = can_take;
  assign accept   = in_valid && can_take;

  subch_bind_table #(
    .ENTRIES (SUBCH_COUNT),
    .DATA_W  (DATA_W)
  ) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept && (act == ACT_BIND)),
    .wr_idx   (in_subch),
    .wr_val   (in_value),
    .rd_idx   (in_subch),
    .rd_val   (lk_val),
    .rd_bound (lk_bound)
  );

  subch_method_decode #(
    .METHOD_W   (METHOD_W),
    .DATA_W     (DATA_W),
    .ID_W       (ID_W),
    .RESV_LIMIT (RESV_LIMIT),
    .ENG_IDS    (ENG_IDS)
  ) decode_i (
    .method    (in_method),
    .bound     (lk_bound),
    .bound_val (lk_val),
    .act       (act),
    .sel       (sel)
  );

  assign pr = {dma_ready, cmp_ready, eng3d_ready, eng2d_ready};

  subch_fwd_stage #(
    .METHOD_W (METHOD_W),
    .DATA_W   (DATA_W),
    .REM_W    (REM_W)
  ) stage_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept && (act == ACT_FWD)),
    .load_sel    (sel),
    .load_method (in_method),
    .load_value  (in_value),
    .load_remain (in_remain),
    .port_ready  (pr),
    .port_valid  (pv),
    .out_method  (st_method),
    .out_value   (st_value),
    .out_remain  (st_remain),
    .can_take    (can_take)
  );

  assign err_set[0] = accept && (act == ACT_UNBOUND);
  assign err_set[1] = accept && (act == ACT_RESERVED);
  assign err_set[2] = accept && (act == ACT_UNKNOWN);

  subch_err_flags #(.FLAGS(3)) flags_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (err_clear),
    .flag  (err_q)
  );

  assign err_unbound  = err_q[0];
  assign err_reserved = err_q[1];
  assign err_unknown  = err_q[2];

  assign eng2d_valid  = pv[ENG_2D];
  assign eng2d_method = st_method;
  assign eng2d_value  = st_value;
  assign eng3d_valid  = pv[ENG_3D];
  assign eng3d_method = st_method;
  assign eng3d_value  = st_value;
  assign eng3d_remain = st_remain;
  assign cmp_valid    = pv[ENG_CMP];
  assign cmp_method   = st_method;
  assign cmp_value    = st_value;
  assign dma_valid    = pv[ENG_DMA];
  assign dma_method   = st_method;
  assign dma_value    = st_value;

endmodule

// File: rtl/subch_router_chk.sv
module subch_router_chk #(
  parameter int METHOD_W   = 13,
  parameter int DATA_W     = 32,
  parameter int RESV_LIMIT = 'h40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                err_clear,
  input logic                in_valid,
  input logic                in_ready,
  input logic [METHOD_W-1:0] in_method,
  input logic [3:0]          eng_valid,
  input logic [3:0]          eng_ready,
  input logic [METHOD_W-1:0] eng3d_method,
  input logic [DATA_W-1:0]   eng3d_value,
  input logic                err_reserved
);

  logic acc;
  assign acc = in_valid && in_ready;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid)); // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eng_valid & ~eng_ready)) |-> !in_ready); // R8

  AST_STALL_HOLDS_3D: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid[1] && !eng_ready[1]) |=>
      (eng_valid[1] && $stable(eng3d_method) && $stable(eng3d_value))); // R8

  AST_BIND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_method == '0)) |=> (eng_valid == 4'b0000)); // R2

  AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_method != '0) && (in_method < METHOD_W'(RESV_LIMIT))) |=>
      (err_reserved && (eng_valid == 4'b0000))); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reserved && !err_clear) |=> err_reserved); // R11

endmodule

bind subch_router subch_router_chk #(
  .METHOD_W   (METHOD_W),
  .DATA_W     (DATA_W),
  .RESV_LIMIT (RESV_LIMIT)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_clear    (err_clear),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_method    (in_method),
  .eng_valid    ({dma_valid, cmp_valid, eng3d_valid, eng2d_valid}),
  .eng_ready    ({dma_ready, cmp_ready, eng3d_ready, eng2d_ready}),
  .eng3d_method (eng3d_method),
  .eng3d_value  (eng3d_value),
  .err_reserved (err_reserved)
);

// File: tb/subch_router_tb_top.sv
`timescale 1ns/1ps
module subch_router_tb_top;

  localparam logic [15:0] I2D = 16'h0201;
  localparam logic [15:0] I3D = 16'h0302;
  localparam logic [15:0] ICP = 16'h0403;
  localparam logic [15:0] IDM = 16'h0504;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_method = '0;
  logic [2:0]  in_subch = '0;
  logic [31:0] in_value = '0;
  logic [15:0] in_remain = '0;
  logic        eng2d_valid, eng3d_valid, cmp_valid, dma_valid;
  logic        eng2d_ready = 1'b1, eng3d_ready = 1'b1, cmp_ready = 1'b1, dma_ready = 1'b1;
  logic [12:0] eng2d_method, eng3d_method, cmp_method, dma_method;
  logic [31:0] eng2d_value, eng3d_value, cmp_value, dma_value;
  logic [15:0] eng3d_remain;
  logic        err_unbound, err_reserved, err_unknown;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  subch_router dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] vld();
    return {dma_valid, cmp_valid, eng3d_valid, eng2d_valid};
  endfunction

  task automatic send(input logic [12:0] m, input logic [2:0] s,
                      input logic [31:0] v, input logic [15:0] r);
    @(negedge clk);
    in_method = m; in_subch = s; in_value = v; in_remain = r; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(vld() == 4'b0, "R1", "valids", vld(), 0);
    chk({err_unbound, err_reserved, err_unknown} == 3'b0, "R1", "flags",
        {err_unbound, err_reserved, err_unknown}, 0);
  endtask

  task automatic t_route_all();
    send(13'h000, 3'd0, {16'h0, I2D}, 16'd0);
    chk(vld() == 4'b0, "R2", "bind silent", vld(), 0);
    send(13'h000, 3'd1, {16'h0, I3D}, 16'd0);
    send(13'h000, 3'd2, {16'h0, ICP}, 16'd0);
    send(13'h000, 3'd3, {16'h0, IDM}, 16'd0);
    send(13'h040, 3'd0, 32'hA0A0_0001, 16'd9);
    chk(vld() == 4'b0001, "R4", "2D routed", vld(), 4'b0001);
    chk(eng2d_method == 13'h040 && eng2d_value == 32'hA0A0_0001, "R4", "2D data",
        {eng2d_method, eng2d_value}, {13'h040, 32'hA0A0_0001});
    send(13'h1F3, 3'd1, 32'hB0B0_0002, 16'd7);
    chk(vld() == 4'b0010, "R4", "3D routed", vld(), 4'b0010);
    chk(eng3d_method == 13'h1F3 && eng3d_value == 32'hB0B0_0002, "R4", "3D data",
        {eng3d_method, eng3d_value}, {13'h1F3, 32'hB0B0_0002});
    chk(eng3d_remain == 16'd7, "R5", "3D remain", eng3d_remain, 7);
    send(13'h1FFF, 3'd2, 32'hC0C0_0003, 16'd0);
    chk(vld() == 4'b0100 && cmp_value == 32'hC0C0_0003 && cmp_method == 13'h1FFF,
        "R4", "compute routed", {vld(), cmp_value}, {4'b0100, 32'hC0C0_0003});
    send(13'h0ABC, 3'd3, 32'hD0D0_0004, 16'd1);
    chk(vld() == 4'b1000 && dma_value == 32'hD0D0_0004 && dma_method == 13'h0ABC,
        "R4", "dma routed", {vld(), dma_value}, {4'b1000, 32'hD0D0_0004});
    @(negedge clk); #1;
    chk(vld() == 4'b0, "R9", "drained", vld(), 0);
  endtask

  task automatic t_reserved();
    send(13'h03F, 3'd0, 32'h1111, 16'd0);
    chk(vld() == 4'b0, "R3", "0x3F dropped", vld(), 0);
    chk(err_reserved == 1'b1, "R3", "flag 0x3F", err_reserved, 1);
    chk(err_unbound == 1'b0 && err_unknown == 1'b0, "R3", "other flags",
        {err_unbound, err_unknown}, 0);
    pulse_clear();
    chk(err_reserved == 1'b0, "R11", "cleared", err_reserved, 0);
    send(13'h001, 3'd1, 32'h2222, 16'd0);
    chk(vld() == 4'b0 && err_reserved == 1'b1, "R3", "method 1",
        {vld(), err_reserved}, 5'b00001);
    repeat (3) @(negedge clk);
    #1;
    chk(err_reserved == 1'b1, "R11", "sticky", err_reserved, 1);
    pulse_clear();
  endtask

  task automatic t_unbound();
    send(13'h040, 3'd7, 32'h3333, 16'd0);
    chk(vld() == 4'b0, "R6", "unbound dropped", vld(), 0);
    chk(err_unbound == 1'b1 && err_unknown == 1'b0, "R6", "unbound flag",
        {err_unbound, err_unknown}, 2'b10);
    pulse_clear();
  endtask

  task automatic t_unknown();
    send(13'h000, 3'd5, 32'h0001_0201, 16'd0);
    send(13'h080, 3'd5, 32'h4444, 16'd0);
    chk(vld() == 4'b0, "R7", "upper bits dropped", vld(), 0);
    chk(err_unknown == 1'b1 && err_unbound == 1'b0, "R7", "unknown flag",
        {err_unknown, err_unbound}, 2'b10);
    pulse_clear();
    send(13'h000, 3'd5, 32'h0000_1234, 16'd0);
    send(13'h080, 3'd5, 32'h5555, 16'd0);
    chk(vld() == 4'b0 && err_unknown == 1'b1, "R7", "odd id",
        {vld(), err_unknown}, 5'b00001);
    pulse_clear();
  endtask

  task automatic t_rebind();
    send(13'h000, 3'd4, {16'h0, IDM}, 16'd0);
    send(13'h050, 3'd4, 32'h6666, 16'd0);
    chk(vld() == 4'b1000, "R10", "first binding", vld(), 4'b1000);
    send(13'h000, 3'd4, {16'h0, ICP}, 16'd0);
    send(13'h051, 3'd4, 32'h7777, 16'd0);
    chk(vld() == 4'b0100 && cmp_value == 32'h7777, "R10", "rebound",
        {vld(), cmp_value}, {4'b0100, 32'h7777});
    send(13'h052, 3'd0, 32'h8888, 16'd0);
    chk(vld() == 4'b0001 && eng2d_value == 32'h8888, "R10", "other subch kept",
        {vld(), eng2d_value}, {4'b0001, 32'h8888});
    send(13'h000, 3'd4, {16'h0, I2D}, 16'd0);
    chk(vld() == 4'b0, "R2", "rebind silent", vld(), 0);
  endtask

  task automatic t_stall();
    eng3d_ready = 1'b0;
    send(13'h100, 3'd1, 32'hAAAA_0001, 16'd3);
    chk(eng3d_valid == 1'b1, "R8", "stalled valid", eng3d_valid, 1);
    @(negedge clk);
    in_method = 13'h101; in_subch = 3'd1; in_value = 32'hAAAA_0002;
    in_remain = 16'd2; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(in_ready == 1'b0, "R8", "input blocked", in_ready, 0);
      chk(eng3d_valid && eng3d_value == 32'hAAAA_0001 && eng3d_method == 13'h100,
          "R8", "held data", {eng3d_valid, eng3d_value}, {1'b1, 32'hAAAA_0001});
      @(negedge clk);
    end
    eng3d_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R8", "ready follows target", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(eng3d_valid && eng3d_value == 32'hAAAA_0002 && eng3d_remain == 16'd2,
        "R8", "second beat", {eng3d_value, eng3d_remain}, {32'hAAAA_0002, 16'd2});
    @(negedge clk); #1;
    chk(vld() == 4'b0, "R9", "after drain", vld(), 0);
  endtask

  task automatic t_clear_vs_set();
    @(negedge clk);
    in_method = 13'h010; in_subch = 3'd0; in_value = 32'h0; in_valid = 1'b1;
    err_clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; err_clear = 1'b0;
    #1;
    chk(err_reserved == 1'b1, "R11", "set beats clear", err_reserved, 1);
    pulse_clear();
    chk(err_reserved == 1'b0, "R11", "clear after", err_reserved, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_route_all();
    t_reserved();
    t_unbound();
    t_unknown();
    t_rebind();
    t_stall();
    t_clear_vs_set();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule